// File: doc/BRIEF.md
# Parallel DAC Bus Master Sequencer

This block sits on the host side of a sixteen-channel, eight-bit, double-buffered DAC that has a level-sensitive parallel port. It runs from one synchronous clock and turns single commands into correctly timed pin sequences. The pins are a four-bit channel address, an eight-bit data bus with a separate drive enable, an active-low chip select, an active-low enable strobe, a read/write select and an active-low load strobe. A command is offered with a valid/ready handshake. The opcode selects one of four actions:

- write one channel and load it,
- write all sixteen input registers and then load them with a single strobe,
- read back one input register,
- run a repeating ramp on one channel with the bus held transparent.

Every timing minimum is given in nanoseconds as a parameter. At elaboration it is turned into a cycle count, rounded up, and each phase of a sequence waits in its own state for that count. Finished commands raise a one-cycle done pulse. For a read, the pulse comes with the captured byte. The DAC converters themselves, any bus arbitration and any firmware lie outside this block.

Top module: `dacbus_seq`

## Requirements
- R1: After reset and whenever idle, chip select, enable and load are high (inactive), read/write is low, the data drive enable is low, cmd_ready is high and done is low.
- R2: A write command (opcode 0) drives cmd_addr and cmd_data with chip select and read/write low and pulses enable low once. It then pulses load. After its done pulse the DAC register of that channel holds cmd_data and every other channel is unchanged.
- R3: Every write pulse keeps enable low for at least LO = max(ceil(EN_LO_NS/CLK_NS), ceil(SETUP_NS/CLK_NS)) cycles, with the data unchanged from the falling to the rising enable edge. Between enable pulses, enable stays high at least HI = max(ceil(EN_HI_NS/CLK_NS), ceil(HOLD_NS/CLK_NS)) cycles.
- R4: A burst command (opcode 1) writes channels 0 to 15 in ascending address order. Channel i takes byte i of cmd_burst, bits [8i+7:8i]. The address changes together with the falling enable edge.
- R5: The load pulse comes only after the last input-register write of a command. During it chip select is high and enable is low, and load stays low at least LO cycles.
- R6: A read command (opcode 2) sets read/write high and chip select low with enable and load high and the data drive enable low. rd_data is the bus_din value sampled RD = max(ceil(ACC_NS/CLK_NS), ceil(ADDR_NS/CLK_NS)) cycles after those pins change.
- R7: Each command ends with exactly one single-cycle done pulse. For a read, the pulse comes in the first cycle with chip select released, and rd_data already holds the sampled byte.
- R8: After a read, the data drive enable stays low for at least REL = ceil(REL_NS/CLK_NS) cycles after chip select rises.
- R9: A ramp command (opcode 3) holds chip select, enable, load and read/write all low on cmd_addr. It starts at code 0 and shows each code for cmd_hold+1 cycles. The next code is the previous code plus cmd_step.
- R10: In ramp mode, when the previous code plus the step exceeds 255 the next code is 0.
- R11: Raising ramp_stop during a ramp releases enable, chip select and load in the next cycle. The channel keeps the last ramp code, and one done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_op | input | 2 | 0 write, 1 burst, 2 read, 3 ramp |
| cmd_addr | input | AW | Channel for write, read and ramp |
| cmd_data | input | DW | Byte for a single write |
| cmd_burst | input | NCH*DW | Bytes for a burst, channel i in bits [8i+7:8i] |
| cmd_step | input | DW | Ramp increment |
| cmd_hold | input | HW | Extra cycles each ramp code is held |
| ramp_stop | input | 1 | Leaves ramp mode |
| rd_data | output | DW | Byte captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | AW | Channel address pins |
| bus_dout | output | DW | Data driven onto the bus |
| bus_doe | output | 1 | Data drive enable |
| bus_din | input | DW | Data bus as seen by the host |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_en_n | output | 1 | Enable strobe, active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_ld_n | output | 1 | DAC load strobe, active low |

## Verification
All pins are registered, so they change on the edge that accepts a command and then hold for exactly LO, HI, RD or REL cycles per phase. The bench therefore measures each phase by counting the falling-edge samples between pin changes and compares the count with its own ceiling arithmetic. For reads, the bench model returns the inverted byte until RD-1 falling-edge samples have passed since the last address or control change. A read that samples early therefore returns wrong data. Results carried by done are checked on the falling edge where done is high, and the following sample must show it low again.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_BURST = 2'd1,
    OP_READ  = 2'd2,
    OP_RAMP  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WLO,
    S_WHI,
    S_LDLO,
    S_LDHI,
    S_RACC,
    S_RREL,
    S_RAMP,
    S_RXIT
  } state_e;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacbus_tmr.sv
module dacbus_tmr #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  // a phase loaded with val lasts val cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  p_tmr_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && val > 1) |=> !zero);

endmodule

// File: rtl/dacbus_ramp.sv
module dacbus_ramp #(
  parameter int DW = 8,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [DW-1:0] step_in,
  input  logic [HW-1:0] hold_in,
  output logic [DW-1:0] code,
  output logic          adv
);

  logic [DW-1:0] step_q;
  logic [HW-1:0] hold_q;
  logic [HW-1:0] hcnt;

  // sum past full scale restarts the ramp at zero
  function automatic logic [DW-1:0] next_code(input logic [DW-1:0] c,
                                              input logic [DW-1:0] s);
    logic [DW:0] sum;
    sum = {1'b0, c} + {1'b0, s};
    return sum[DW] ? '0 : sum[DW-1:0];
  endfunction

  assign adv = run && (hcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      step_q <= '0;
      hold_q <= '0;
      hcnt   <= '0;
    end else if (start) begin
      code   <= '0;
      step_q <= step_in;
      hold_q <= hold_in;
      hcnt   <= hold_in;
    end else if (adv) begin
      code <= next_code(code, step_q);
      hcnt <= hold_q;
    end else if (run) begin
      hcnt <= hcnt - 1'b1;
    end
  end

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && code == '1 && step_q != '0) |=> (code == '0));

  p_dwell_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv && !start) |=> $stable(code));

endmodule

// File: rtl/dacbus_seq.sv
module dacbus_seq
  import dacbus_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int HW       = 8,
  parameter int CLK_NS   = 10,
  parameter int EN_LO_NS = 40,
  parameter int EN_HI_NS = 40,
  parameter int SETUP_NS = 40,
  parameter int HOLD_NS  = 10,
  parameter int ACC_NS   = 120,
  parameter int ADDR_NS  = 160,
  parameter int REL_NS   = 150,
  localparam int NCH     = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  input  logic [NCH*DW-1:0] cmd_burst,
  input  logic [DW-1:0]     cmd_step,
  input  logic [HW-1:0]     cmd_hold,
  input  logic              ramp_stop,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  output logic              bus_cs_n,
  output logic              bus_en_n,
  output logic              bus_rw,
  output logic              bus_ld_n
);

  localparam int LO_C  = imax(ns_to_cyc(EN_LO_NS, CLK_NS), ns_to_cyc(SETUP_NS, CLK_NS));
  localparam int HI_C  = imax(ns_to_cyc(EN_HI_NS, CLK_NS), ns_to_cyc(HOLD_NS, CLK_NS));
  localparam int RD_C  = imax(ns_to_cyc(ACC_NS, CLK_NS), ns_to_cyc(ADDR_NS, CLK_NS));
  localparam int REL_C = ns_to_cyc(REL_NS, CLK_NS);
  localparam int MAXC  = imax(imax(LO_C, HI_C), imax(RD_C, REL_C));
  localparam int TW    = $clog2(MAXC + 1);
  localparam logic [TW-1:0] LO_V   = TW'(LO_C);
  localparam logic [TW-1:0] HI_V   = TW'(HI_C);
  localparam logic [TW-1:0] RD_V   = TW'(RD_C);
  localparam logic [TW-1:0] REL_V  = TW'(REL_C);
  localparam logic [TW-1:0] SAT_V  = TW'(MAXC);
  localparam logic [AW-1:0] LAST_CH = AW'(NCH - 1);

  state_e          st;
  op_e             op;
  logic [AW-1:0]   ch_q, last_q, ch_nx;
  logic [DW-1:0]   dout_q, rd_q;
  logic [NCH*DW-1:0] bvec_q;
  logic            done_q, cs_n_q, en_n_q, rw_q, ld_n_q, doe_q;
  logic            tz, tmr_ld;
  logic [TW-1:0]   tmr_val;
  logic [DW-1:0]   r_code;

  // named internal events
  logic accept, ramp_on, ramp_start, ramp_run, ramp_adv, rd_sample;

  assign op         = op_e'(cmd_op);
  assign accept     = (st == S_IDLE) && cmd_valid;
  assign ramp_on    = (st == S_RAMP);
  assign ramp_start = accept && (op == OP_RAMP);
  assign ramp_run   = ramp_on && !ramp_stop;
  assign rd_sample  = (st == S_RACC) && tz;
  assign ch_nx      = ch_q + 1'b1;

  dacbus_tmr #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_ld),
    .val   (tmr_val),
    .zero  (tz)
  );

  dacbus_ramp #(.DW(DW), .HW(HW)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ramp_start),
    .run     (ramp_run),
    .step_in (cmd_step),
    .hold_in (cmd_hold),
    .code    (r_code),
    .adv     (ramp_adv)
  );

  // length of the phase entered on this edge
  always_comb begin
    tmr_ld  = 1'b0;
    tmr_val = LO_V;
    case (st)
      S_IDLE: if (cmd_valid) begin
        tmr_ld  = 1'b1;
        tmr_val = (op == OP_READ) ? RD_V : LO_V;
      end
      S_WLO:  if (tz) begin tmr_ld = 1'b1; tmr_val = HI_V; end
      S_WHI:  if (tz) begin tmr_ld = 1'b1; tmr_val = LO_V; end
      S_LDLO: if (tz) begin tmr_ld = 1'b1; tmr_val = HI_V; end
      S_RACC: if (tz) begin tmr_ld = 1'b1; tmr_val = REL_V; end
      S_RAMP: if (ramp_stop) begin tmr_ld = 1'b1; tmr_val = HI_V; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ch_q   <= '0;
      last_q <= '0;
      dout_q <= '0;
      bvec_q <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
      cs_n_q <= 1'b1;
      en_n_q <= 1'b1;
      rw_q   <= 1'b0;
      ld_n_q <= 1'b1;
      doe_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          case (op)
            OP_WRITE: begin
              ch_q   <= cmd_addr;
              last_q <= cmd_addr;
              dout_q <= cmd_data;
              cs_n_q <= 1'b0;
              en_n_q <= 1'b0;
              doe_q  <= 1'b1;
              st     <= S_WLO;
            end
            OP_BURST: begin
              ch_q   <= '0;
              last_q <= LAST_CH;
              bvec_q <= cmd_burst;
              dout_q <= cmd_burst[DW-1:0];
              cs_n_q <= 1'b0;
              en_n_q <= 1'b0;
              doe_q  <= 1'b1;
              st     <= S_WLO;
            end
            OP_READ: begin
              ch_q   <= cmd_addr;
              cs_n_q <= 1'b0;
              rw_q   <= 1'b1;
              st     <= S_RACC;
            end
            default: begin
              ch_q   <= cmd_addr;
              cs_n_q <= 1'b0;
              en_n_q <= 1'b0;
              ld_n_q <= 1'b0;
              doe_q  <= 1'b1;
              st     <= S_RAMP;
            end
          endcase
        end
        S_WLO: if (tz) begin
          en_n_q <= 1'b1;
          st     <= S_WHI;
        end
        S_WHI: if (tz) begin
          if (ch_q != last_q) begin
            ch_q   <= ch_nx;
            dout_q <= bvec_q[int'(ch_nx)*DW +: DW];
            en_n_q <= 1'b0;
            st     <= S_WLO;
          end else begin
            cs_n_q <= 1'b1;
            en_n_q <= 1'b0;
            ld_n_q <= 1'b0;
            st     <= S_LDLO;
          end
        end
        S_LDLO: if (tz) begin
          en_n_q <= 1'b1;
          ld_n_q <= 1'b1;
          st     <= S_LDHI;
        end
        S_LDHI: if (tz) begin
          doe_q  <= 1'b0;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        S_RACC: if (tz) begin
          rd_q   <= bus_din;
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          st     <= S_RREL;
        end
        S_RREL: if (tz) begin
          rw_q <= 1'b0;
          st   <= S_IDLE;
        end
        S_RAMP: if (ramp_stop) begin
          dout_q <= r_code;
          cs_n_q <= 1'b1;
          en_n_q <= 1'b1;
          ld_n_q <= 1'b1;
          st     <= S_RXIT;
        end
        S_RXIT: if (tz) begin
          doe_q  <= 1'b0;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign rd_data   = rd_q;
  assign done      = done_q;
  assign bus_addr  = ch_q;
  assign bus_dout  = ramp_on ? r_code : dout_q;
  assign bus_doe   = doe_q;
  assign bus_cs_n  = cs_n_q;
  assign bus_en_n  = en_n_q;
  assign bus_rw    = rw_q;
  assign bus_ld_n  = ld_n_q;

  // observation counters for the timing windows
  logic [TW-1:0] en_lo_run, rel_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo_run <= '0;
      rel_run   <= SAT_V;
    end else begin
      en_lo_run <= bus_en_n ? '0 : ((en_lo_run == SAT_V) ? SAT_V : en_lo_run + 1'b1);
      rel_run   <= (!bus_cs_n && bus_rw) ? '0 :
                   ((rel_run == SAT_V) ? SAT_V : rel_run + 1'b1);
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bus_cs_n && bus_en_n && bus_ld_n && !bus_rw && !bus_doe));

  p_en_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_en_n) && st != S_RXIT) |-> (en_lo_run >= LO_V));

  p_ld_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_ld_n) && !ramp_on) |-> (ch_q == last_q));

  p_ld_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ld_n && !ramp_on) |-> (bus_cs_n && !bus_en_n));

  p_read_nodrive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && bus_rw) |-> (!bus_doe && bus_en_n && bus_ld_n));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_read_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |=> (done && bus_cs_n));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_doe) |-> (rel_run >= REL_V));

  p_ramp_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_on |-> (!bus_cs_n && !bus_en_n && !bus_ld_n && !bus_rw));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_on && ramp_stop) |=> (bus_en_n && bus_cs_n && bus_ld_n));

endmodule

// File: tb/sim_dacbus_seq.sv
module sim_dacbus_seq;

  localparam int CLK_NS = 10;
  localparam int LO_C   = 4;   // max(ceil(40/10), ceil(40/10))
  localparam int HI_C   = 4;   // max(ceil(40/10), ceil(10/10))
  localparam int RD_C   = 16;  // max(ceil(120/10), ceil(160/10))
  localparam int REL_C  = 15;  // ceil(150/10)

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [1:0]   cmd_op = 2'd0;
  logic [3:0]   cmd_addr = 4'd0;
  logic [7:0]   cmd_data = 8'd0;
  logic [127:0] cmd_burst = '0;
  logic [7:0]   cmd_step = 8'd1;
  logic [7:0]   cmd_hold = 8'd0;
  logic         ramp_stop = 1'b0;
  logic [7:0]   rd_data;
  logic         done;
  logic [3:0]   bus_addr;
  logic [7:0]   bus_dout;
  logic         bus_doe;
  logic [7:0]   bus_din = 8'd0;
  logic         bus_cs_n, bus_en_n, bus_rw, bus_ld_n;

  dacbus_seq #(.CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_burst(cmd_burst), .cmd_step(cmd_step), .cmd_hold(cmd_hold),
    .ramp_stop(ramp_stop), .rd_data(rd_data), .done(done),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_en_n(bus_en_n),
    .bus_rw(bus_rw), .bus_ld_n(bus_ld_n)
  );

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model of the DAC port and pin monitors
  logic [7:0] inreg [16];
  logic [7:0] dacreg[16];
  logic [7:0] exp_dac[16];
  logic       p_en = 1'b1, p_cs = 1'b1, p_rw = 1'b0, p_ld = 1'b1, p_doe = 1'b0;
  logic       p_ramp = 1'b0;
  logic [3:0] p_addr = 4'd0;
  logic [7:0] dout_fall = 8'd0, last_code = 8'd0;
  int lo_run = 0, hi_run = 1000, acc = 0, rgap = 0, dwell = 0, wraps = 0;
  int wr_n = 0, ld_at = -1, rstep = 1, rhold = 0;
  bit rpend = 0, mon_on = 0;
  logic [3:0] wr_log[32];

  initial begin
    for (int i = 0; i < 16; i++) begin
      inreg[i] = 8'd0; dacreg[i] = 8'd0; exp_dac[i] = 8'd0;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      logic ramp_pins;
      logic chg;
      int   nx;
      if (!bus_cs_n && !bus_rw && !bus_en_n) inreg[bus_addr] = bus_dout;
      if (!bus_ld_n && !bus_en_n)
        for (int i = 0; i < 16; i++) dacreg[i] = inreg[i];
      // enable edges
      if (bus_en_n && !p_en) begin
        if (p_ld && !p_cs && !p_rw) begin
          chk(lo_run >= LO_C, "R3 enable low width", lo_run, LO_C);
          chk(bus_dout == dout_fall, "R3 data stable while enable low", bus_dout, dout_fall);
          if (wr_n < 32) wr_log[wr_n] = p_addr;
          wr_n++;
        end else if (!p_ld && p_cs) begin
          chk(lo_run >= LO_C, "R5 load low width", lo_run, LO_C);
        end
        hi_run = 1;
      end else if (!bus_en_n && p_en) begin
        chk(hi_run >= HI_C, "R3 enable high width", hi_run, HI_C);
        dout_fall = bus_dout;
        lo_run = 1;
      end else if (bus_en_n) hi_run++;
      else lo_run++;
      if (!bus_ld_n && p_ld && !(!bus_cs_n && !bus_en_n && !bus_rw)) begin
        ld_at = wr_n;
        chk(bus_cs_n && !bus_en_n, "R5 load with select high enable low", {bus_cs_n, bus_en_n}, 2);
      end
      // ramp
      ramp_pins = !bus_cs_n && !bus_en_n && !bus_ld_n && !bus_rw;
      if (ramp_pins) begin
        if (!p_ramp) begin
          chk(bus_dout == 8'd0, "R9 ramp start code", bus_dout, 0);
          dwell = 1;
        end else if (bus_dout == last_code) begin
          dwell++;
        end else begin
          chk(dwell == rhold + 1, "R9 ramp dwell", dwell, rhold + 1);
          nx = int'(last_code) + rstep;
          if (nx > 255) begin
            nx = 0;
            chk(bus_dout == 8'd0, "R10 ramp restart", bus_dout, 0);
            wraps++;
          end else begin
            chk(int'(bus_dout) == nx, "R9 ramp step", bus_dout, nx);
          end
          dwell = 1;
        end
        last_code = bus_dout;
      end
      // read data and release
      if (!bus_cs_n && bus_rw)
        chk(!bus_doe && bus_en_n && bus_ld_n, "R6 read pins", {bus_doe, bus_en_n, bus_ld_n}, 3);
      if (!bus_cs_n && bus_rw) begin rgap = 0; rpend = 1; end
      else rgap++;
      if (bus_doe && !p_doe && rpend) begin
        chk(rgap >= REL_C, "R8 bus release gap", rgap, REL_C);
        rpend = 0;
      end
      chg = (bus_addr != p_addr) || (bus_cs_n != p_cs) || (bus_rw != p_rw);
      if (chg) acc = 0; else acc++;
      bus_din = (!bus_cs_n && bus_rw && acc >= RD_C - 1) ? inreg[bus_addr] : ~inreg[bus_addr];
      p_en = bus_en_n; p_cs = bus_cs_n; p_rw = bus_rw; p_ld = bus_ld_n;
      p_doe = bus_doe; p_addr = bus_addr; p_ramp = ramp_pins;
    end
  end

  task automatic send(input logic [1:0] op, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // returns at the negedge where done is high
  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, tag, done, 1);
  endtask

  task automatic done_gone(input string tag);
    @(negedge clk);
    chk(!done, tag, done, 0);
  endtask

  task automatic cmp_dac(input string tag);
    int bad = 0;
    for (int i = 0; i < 16; i++) if (dacreg[i] !== exp_dac[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && bus_en_n && bus_ld_n && !bus_rw && !bus_doe && cmd_ready && !done,
        "R1 reset pins", {bus_cs_n, bus_en_n, bus_ld_n, bus_rw, bus_doe, cmd_ready, done}, 7'b1110010);
    mon_on = 1;

    // single writes on every channel
    for (int ch = 0; ch < 16; ch++) begin
      d = 8'(ch * 37 + 5);
      wr_n = 0; ld_at = -1;
      send(2'd0, 4'(ch), d);
      wait_done("R7 write done");
      exp_dac[ch] = d;
      cmp_dac("R2 single write updates only its channel");
      chk(wr_n == 1 && ld_at == 1, "R5 load after the write", ld_at, 1);
      done_gone("R7 write done one cycle");
      chk(cmd_ready && bus_cs_n && bus_en_n && !bus_doe, "R1 idle after write", cmd_ready, 1);
    end

    // read back every channel
    for (int ch = 0; ch < 16; ch++) begin
      send(2'd2, 4'(ch), 8'd0);
      wait_done("R7 read done");
      chk(rd_data == exp_dac[ch], "R6 read data", rd_data, exp_dac[ch]);
      chk(bus_cs_n, "R7 select released at done", bus_cs_n, 1);
      done_gone("R7 read done one cycle");
    end

    // burst
    for (int i = 0; i < 16; i++) cmd_burst[i*8 +: 8] = 8'(i * 17 + 3) ^ 8'h5A;
    wr_n = 0; ld_at = -1;
    send(2'd1, 4'd0, 8'd0);
    wait_done("R7 burst done");
    for (int i = 0; i < 16; i++) exp_dac[i] = cmd_burst[i*8 +: 8];
    cmp_dac("R4 burst contents");
    chk(wr_n == 16, "R4 burst write count", wr_n, 16);
    chk(ld_at == 16, "R5 single load after last write", ld_at, 16);
    for (int i = 0; i < 16; i++)
      chk(wr_log[i] == 4'(i), "R4 burst address order", wr_log[i], i);
    done_gone("R7 burst done one cycle");
    send(2'd2, 4'd11, 8'd0);
    wait_done("R7 read done");
    chk(rd_data == exp_dac[11], "R6 read after burst", rd_data, exp_dac[11]);

    // ramp step 1, hold 0
    rstep = 1; rhold = 0; wraps = 0;
    cmd_step = 8'd1; cmd_hold = 8'd0;
    send(2'd3, 4'd5, 8'd0);
    repeat (600) @(negedge clk);
    chk(wraps >= 2, "R10 ramp wrapped", wraps, 2);
    chk(bus_addr == 4'd5, "R9 ramp channel", bus_addr, 5);
    ramp_stop = 1'b1;
    wait_done("R11 abort done");
    ramp_stop = 1'b0;
    exp_dac[5] = last_code;
    cmp_dac("R11 channel keeps last ramp code");
    done_gone("R7 abort done one cycle");
    chk(bus_cs_n && bus_en_n && bus_ld_n, "R11 strobes released", {bus_cs_n, bus_en_n, bus_ld_n}, 7);

    // ramp step 100, hold 2
    rstep = 100; rhold = 2; wraps = 0;
    cmd_step = 8'd100; cmd_hold = 8'd2;
    send(2'd3, 4'd9, 8'd0);
    repeat (50) @(negedge clk);
    chk(wraps >= 3, "R10 large step restart", wraps, 3);
    ramp_stop = 1'b1;
    wait_done("R11 abort done");
    ramp_stop = 1'b0;
    exp_dac[9] = last_code;
    cmp_dac("R11 second ramp keeps last code");
    send(2'd2, 4'd9, 8'd0);
    wait_done("R7 read done");
    chk(rd_data == exp_dac[9], "R11 input register holds ramp code", rd_data, exp_dac[9]);

    // write right after a read exercises the release gap
    send(2'd0, 4'd3, 8'hC3);
    wait_done("R7 write done");
    exp_dac[3] = 8'hC3;
    cmp_dac("R2 write after read");

    repeat (5) @(negedge clk);
    summary();
  end

endmodule